// File: doc/BRIEF.md
# Serial Word Memory Slave Command Engine

This block is the device-side logic of a word-organized non-volatile memory that is reached over a three-wire serial link. The link has an active-low select, a serial clock and a data input, plus a data output with a separate enable for tri-state. The host opens a frame by pulling select low. Each frame carries an 8-bit op-code, an 8-bit address byte and a 16-bit data word, all MSB first. The block decodes four commands: read, write, write-enable and write-disable. It holds a software write-enable latch and runs a programming interval of fixed length in system clock cycles. During that interval the ready pin is low and no command is accepted.

The serial clock level at the moment select falls picks the mode. A high level starts command reception. A low level starts status output, where the data pin shows ready or busy. The write-inhibit input blocks new writes. If it is raised while a write is being programmed, the write is cut short and the word is left holding all ones. The serial pins are oversampled by the system clock. The array is a register file of 16-bit words, and its size is set by a parameter.

Top module: `eep_serial_slave`

## Requirements
- R1: After reset, ready_o is 1, sdo_oe_o is 0, the write-enable latch is clear and every word of the array reads 0x0000.
- R2: sdi_i is taken on each rising serial clock edge, MSB first. The op-codes are 0xA8 (read), 0xA4 (write), 0xA3 (write-enable) and 0xA0 (write-disable). With ADDR_W=9, op-code bit 0 of read and write carries address bit 8 and the address byte carries bits 7..0. With ADDR_W=7, the last address byte bit is ignored.
- R3: For a read, one data bit is driven per falling serial clock edge, starting with the falling edge after the 16th rising edge, MSB first. The address then increments after every word and wraps from the last word to word 0, for as long as select stays low.
- R4: A select fall with the serial clock high starts command reception. A select fall with the serial clock low starts status output, where sdo_oe_o is 1 and sdo_o is 1 when ready and 0 when busy. This works even during programming.
- R5: Status output ends when select rises. It also ends at the first rising edge that samples sdi_i=1, and that bit counts as op-code bit 7. Rising edges that sample 0 are ignored.
- R6: sdo_oe_o is 0 whenever no read data or status is being shown, and it is 0 in the cycle after any cycle with select high.
- R7: Write-enable sets the latch and write-disable clears it. A write with the latch clear changes nothing. Reads do not depend on the latch.
- R8: A write starts at the 32nd rising edge. ready_o is then low for exactly PROG_CYC cycles, after which the word holds the new data.
- R9: A write frame that completes while wr_inhibit_i is 1 is not executed.
- R10: Raising wr_inhibit_i during programming makes ready_o 1 in the next cycle and leaves the addressed word at 0xFFFF.
- R11: While busy, a command frame is ignored until select rises. It produces no output and does not change the latch.
- R12: If select rises before a frame is complete, the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_ni | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| wr_inhibit_i | input | 1 | Write inhibit and programming abort |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| ready_o | output | 1 | 1 when idle, 0 while programming |

## Verification
The assertions assume that sel_ni, sck_i and sdi_i are already synchronous to clk_i. They also assume each serial clock level is held for at least one system clock cycle, so that every serial edge is seen exactly once. The bench meets both assumptions by changing the serial pins only on falling edges of clk_i and holding each serial clock phase for two cycles. It sets the clock level one cycle before select falls and raises select together with a high clock. wr_inhibit_i is changed only on falling clock edges, so the abort point lands on a known cycle.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_RD   = 8'hA8;
  localparam logic [7:0] OP_WR   = 8'hA4;
  localparam logic [7:0] OP_WREN = 8'hA3;
  localparam logic [7:0] OP_WRDS = 8'hA0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_STAT, ST_READ, ST_HOLD
  } eep_st_e;

  // wide: op-code bit 0 carries the top address bit
  function automatic logic op_is_rd(logic [7:0] op, logic wide);
    return wide ? (op[7:1] == OP_RD[7:1]) : (op == OP_RD);
  endfunction

  function automatic logic op_is_wr(logic [7:0] op, logic wide);
    return wide ? (op[7:1] == OP_WR[7:1]) : (op == OP_WR);
  endfunction
endpackage

// File: rtl/eep_pin_edge.sv
module eep_pin_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic sel_ni,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic sel_fall_o
);
  logic sck_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b1;
      sel_q <= 1'b1;
    end else begin
      sck_q <= sck_i;
      sel_q <= sel_ni;
    end
  end

  assign sck_rise_o = sck_i & ~sck_q;
  assign sck_fall_o = ~sck_i & sck_q;
  assign sel_fall_o = ~sel_ni & sel_q;
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int PROG_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic commit_o,
  output logic fail_o
);
  localparam int CW = $clog2(PROG_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(PROG_CYC - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign fail_o   = busy_q & abort_i;
  assign commit_o = busy_q & ~abort_i & (cnt_q == LAST);
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (fail_o || commit_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  // R8
  prog_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q && !abort_i) |=> busy_q);
  // R10
  prog_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && abort_i) |=> !busy_q);
endmodule

// File: rtl/eep_word_array.sv
module eep_word_array #(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eep_serial_slave.sv
module eep_serial_slave #(
  parameter int ADDR_W   = 9,
  parameter int PROG_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ni,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic wr_inhibit_i,
  output logic sdo_o,
  output logic sdo_oe_o,
  output logic ready_o
);
  import eep_pkg::*;

  localparam int  WORD_W = 16;
  localparam logic WIDE  = (ADDR_W > 8);

  logic sck_rise, sck_fall, sel_fall;
  logic busy, commit, fail, start;

  eep_st_e           st_q;
  logic [14:0]       frame_q;
  logic [15:0]       nxt;
  logic [5:0]        cnt_q, cnt_n;
  logic              op_wr_q, wel_q;
  logic [ADDR_W-1:0] wa_q, ra_q, fa;
  logic [WORD_W-1:0] wdata_q, rdata, sh_q;
  logic [3:0]        bcnt_q;
  logic              do_q, rd_act_q;
  logic              mem_we;
  logic [WORD_W-1:0] mem_wd;

  eep_pin_edge u_edge (
    .clk_i, .rst_ni, .sck_i, .sel_ni,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .sel_fall_o(sel_fall)
  );

  eep_prog_timer #(.PROG_CYC(PROG_CYC)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .abort_i(wr_inhibit_i),
    .busy_o(busy), .commit_o(commit), .fail_o(fail)
  );

  assign mem_we = commit | fail;
  assign mem_wd = fail ? '1 : wdata_q;

  eep_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .clk_i, .rst_ni, .we_i(mem_we), .waddr_i(wa_q), .wdata_i(mem_wd),
    .raddr_i(ra_q), .rdata_o(rdata)
  );

  assign nxt   = {frame_q, sdi_i};
  assign cnt_n = cnt_q + 1'b1;

  // address field: nxt[15:8] op-code, nxt[7:0] address byte
  generate
    if (ADDR_W > 8) begin : g_wide
      assign fa = nxt[8:0];
    end else if (ADDR_W == 8) begin : g_byte
      assign fa = nxt[7:0];
    end else begin : g_narrow
      assign fa = nxt[7:1];
    end
  endgenerate

  assign start = (st_q == ST_RX) && !sel_ni && sck_rise && (cnt_n == 6'd32)
               && op_wr_q && wel_q && !wr_inhibit_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      frame_q  <= '0;
      cnt_q    <= '0;
      op_wr_q  <= 1'b0;
      wel_q    <= 1'b0;
      wa_q     <= '0;
      ra_q     <= '0;
      wdata_q  <= '0;
      sh_q     <= '0;
      bcnt_q   <= '0;
      do_q     <= 1'b0;
      rd_act_q <= 1'b0;
    end else if (sel_ni) begin
      st_q     <= ST_IDLE;
      rd_act_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (sel_fall) begin
          cnt_q <= '0;
          if (!sck_i)    st_q <= ST_STAT;
          else if (busy) st_q <= ST_HOLD;
          else           st_q <= ST_RX;
        end
        ST_STAT: if (sck_rise && sdi_i) begin
          // leading 1 opens a frame as op-code bit 7
          frame_q <= nxt[14:0];
          cnt_q   <= 6'd1;
          st_q    <= busy ? ST_HOLD : ST_RX;
        end
        ST_RX: if (sck_rise) begin
          frame_q <= nxt[14:0];
          cnt_q   <= cnt_n;
          if (cnt_n == 6'd8) begin
            if (op_is_rd(nxt[7:0], WIDE) || op_is_wr(nxt[7:0], WIDE)) begin
              op_wr_q <= op_is_wr(nxt[7:0], WIDE);
            end else begin
              if (nxt[7:0] == OP_WREN) wel_q <= 1'b1;
              if (nxt[7:0] == OP_WRDS) wel_q <= 1'b0;
              st_q <= ST_HOLD;
            end
          end else if (cnt_n == 6'd16) begin
            if (op_wr_q) begin
              wa_q <= fa;
            end else begin
              ra_q   <= fa;
              bcnt_q <= '0;
              st_q   <= ST_READ;
            end
          end else if (cnt_n == 6'd32) begin
            wdata_q <= nxt;
            st_q    <= ST_HOLD;
          end
        end
        ST_READ: if (sck_fall) begin
          rd_act_q <= 1'b1;
          bcnt_q   <= bcnt_q + 1'b1;
          if (bcnt_q == 4'd0) begin
            do_q <= rdata[WORD_W-1];
            sh_q <= {rdata[WORD_W-2:0], 1'b0};
          end else begin
            do_q <= sh_q[WORD_W-1];
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
          end
          if (bcnt_q == 4'd15) ra_q <= ra_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign ready_o  = ~busy;
  assign sdo_oe_o = (st_q == ST_STAT) | ((st_q == ST_READ) & rd_act_q);
  assign sdo_o    = (st_q == ST_STAT) ? ~busy
                  : (((st_q == ST_READ) & rd_act_q) ? do_q : 1'b0);

  // R7
  wel_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> wel_q);
  // R6
  desel_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> !sdo_oe_o);
  // R11
  busy_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (st_q != ST_READ));
  // R8
  busy_from_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !$past(!ready_o)) |-> $past(start));
endmodule

// File: tb/sim_eep_serial_slave.sv
module sim_eep_serial_slave;
  localparam int AW    = 9;
  localparam int PROG  = 24;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sck = 1'b1, sdi = 1'b0, inh = 1'b0;
  logic sdo, sdo_oe, rdy;

  int checks = 0, fails = 0;
  int run = 0, last_len = 0;
  bit done = 1'b0;
  logic [15:0] model [DEPTH];

  always #2 clk = ~clk;

  eep_serial_slave #(.ADDR_W(AW), .PROG_CYC(PROG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .sck_i(sck), .sdi_i(sdi),
    .wr_inhibit_i(inh), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .ready_o(rdy)
  );

  always @(negedge clk) begin
    if (!rdy) run++;
    else if (run != 0) begin last_len = run; run = 0; end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_cmd();
    sck = 1'b1; tick(1); sel_n = 1'b0; tick(1);
  endtask

  task automatic begin_stat();
    sck = 1'b0; tick(1); sel_n = 1'b0; tick(2);
  endtask

  task automatic end_sel();
    sel_n = 1'b1; sck = 1'b1; tick(2);
  endtask

  task automatic put_bit(logic b);
    sck = 1'b0; sdi = b; tick(2); sck = 1'b1; tick(2);
  endtask

  task automatic send(logic [15:0] v, int n);
    for (int i = n - 1; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic get_word(output logic [15:0] w, output bit oe_ok);
    oe_ok = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      sck = 1'b0; tick(2);
      w[i] = sdo; if (!sdo_oe) oe_ok = 1'b0;
      sck = 1'b1; tick(2);
    end
  endtask

  function automatic logic [7:0] op_byte(logic [6:0] hi, int a);
    return {hi, 1'(a >> 8)};
  endfunction

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !rdy; i++) tick(1);
    tick(1);
  endtask

  task automatic cmd8(logic [7:0] op);
    begin_cmd(); send(16'(op), 8); end_sel();
  endtask

  task automatic write_frame(int a, logic [15:0] d);
    begin_cmd();
    send(16'(op_byte(7'h52, a)), 8); send(16'(a[7:0]), 8); send(d, 16);
    end_sel();
  endtask

  task automatic read_check(int a, int n, string req);
    logic [15:0] w; bit ok;
    begin_cmd();
    send(16'(op_byte(7'h54, a)), 8); send(16'(a[7:0]), 8);
    for (int k = 0; k < n; k++) begin
      int ad = (a + k) % DEPTH;
      get_word(w, ok);
      check(ok && w == model[ad], req, int'(w), int'(model[ad]));
    end
    end_sel();
  endtask

  function automatic logic [15:0] pat(int a);
    return 16'((a * 40503) ^ 16'h5A3C);
  endfunction

  initial begin
    logic [15:0] w; bit ok;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'h0000;
    tick(3); rst_n = 1'b1; tick(2);
    // R1 reset outputs
    check(rdy == 1'b1 && sdo_oe == 1'b0, "R1", {rdy, sdo_oe}, 2'b10);
    read_check(16'h1F0, 20, "R1 array clear wrap R3");

    // R7 write with latch clear ignored
    write_frame(5, 16'h1234); tick(2);
    check(rdy == 1'b1, "R7 no busy without enable", rdy, 1);
    read_check(5, 1, "R7 word unchanged");

    // R4 status mode when idle
    begin_stat();
    check(sdo_oe == 1'b1 && sdo == 1'b1, "R4 status ready", {sdo_oe, sdo}, 2'b11);
    put_bit(1'b0);
    check(sdo_oe == 1'b1, "R5 zero bit keeps status", sdo_oe, 1);
    end_sel();
    check(sdo_oe == 1'b0, "R6 select high disables", sdo_oe, 0);

    // R8 full sweep of the array
    cmd8(8'hA3);
    for (int a = 0; a < DEPTH; a++) begin
      write_frame(a, pat(a)); model[a] = pat(a);
      wait_ready();
      if (a == 0 || a == DEPTH - 1)
        check(last_len == PROG, "R8 busy length", last_len, PROG);
    end
    read_check(0, DEPTH, "R2 R3 sweep");
    read_check(DEPTH - 2, 3, "R3 wrap");

    // R4 status while busy, then ready live
    write_frame(300, 16'hBEEF); model[300] = 16'hBEEF;
    begin_stat();
    check(sdo_oe == 1'b1 && sdo == 1'b0, "R4 status busy", {sdo_oe, sdo}, 2'b10);
    for (int i = 0; i < 2000 && !rdy; i++) tick(1);
    tick(1);
    check(sdo == 1'b1, "R4 status turns ready", sdo, 1);
    // R5 leading one starts a read frame
    put_bit(1'b1); tick(1);
    check(sdo_oe == 1'b0, "R5 status ends on leading one", sdo_oe, 0);
    send(16'(op_byte(7'h54, 300)), 7); send(16'd300 & 16'hFF, 8);
    get_word(w, ok);
    check(ok && w == 16'hBEEF, "R5 read after status", int'(w), 16'hBEEF);
    end_sel();

    // R11 commands while busy are ignored
    write_frame(7, 16'h0F0F); model[7] = 16'h0F0F;
    begin_cmd();
    send(16'(op_byte(7'h54, 7)), 8); send(16'd7, 8);
    get_word(w, ok);
    check(sdo_oe == 1'b0 && !ok, "R11 no output while busy", sdo_oe, 0);
    end_sel(); wait_ready();
    write_frame(8, 16'hAAAA); model[8] = 16'hAAAA;
    cmd8(8'hA0); wait_ready();
    write_frame(9, 16'h5555); model[9] = 16'h5555; wait_ready();
    read_check(7, 3, "R11 latch kept through busy");

    // R9 inhibit at frame completion
    inh = 1'b1; write_frame(10, 16'h1111); tick(2);
    check(rdy == 1'b1, "R9 inhibited write", rdy, 1);
    inh = 1'b0;
    read_check(10, 1, "R9 word unchanged");

    // R12 abandoned frame
    begin_cmd();
    send(16'(op_byte(7'h52, 11)), 8); send(16'd11, 8); send(16'hCC, 8);
    end_sel(); tick(2);
    check(rdy == 1'b1, "R12 partial frame dropped", rdy, 1);
    read_check(11, 1, "R12 word unchanged");

    // R10 abort during programming
    write_frame(12, 16'h0000);
    tick(3); inh = 1'b1; tick(1);
    check(rdy == 1'b1, "R10 ready next cycle", rdy, 1);
    inh = 1'b0; model[12] = 16'hFFFF; tick(2);
    read_check(12, 1, "R10 word all ones");

    // R7 write-disable clears latch
    cmd8(8'hA0);
    write_frame(13, 16'h7777); tick(2);
    check(rdy == 1'b1, "R7 disabled write", rdy, 1);
    read_check(13, 1, "R7 read independent of latch");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule